// File: doc/BRIEF.md
# GPIO Bank Event Register Block

This block serves one bank of up to 32 general-purpose I/O lines through a small word-addressed register bus. Outbound data sits in a write latch that drives the output pins, and a direction register drives the per-line output enables. Inbound pins pass through a multi-flop synchronizer. A read of the value register returns the synchronized pin level, not the latch. Because of that, a separate read-back register returns the latch contents unchanged.

Each line has its own event detector. Three per-line type bits choose how it fires: on a rising edge, on a falling edge, on both edges, while the line is high, or while it is low. A detected event sets a sticky status bit whether or not the line is enabled. Software clears status bits by writing ones to them. One interrupt output is raised while any enabled line has its status bit set.

Register byte offsets: 0x00 value (read gives the synchronized pins, write loads the latch), 0x04 direction, 0x08 enable, 0x0C polarity (type0), 0x10 level/edge (type1), 0x14 dual-edge (type2), 0x18 status, 0x1C latch read-back. Reads are combinational from `reg_addr`. A write takes effect at the clock edge where `reg_wen` is high.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, every register reads 0, `pins_out` and `pins_oe` are 0, and `irq` is low.
- R2: Offset 0x00 reads the pin level delayed by two clock edges through the synchronizer. A pin change is not visible one edge after it is sampled, and the written latch value never appears at this offset.
- R3: Offset 0x1C reads the last value written to 0x00. `pins_out` equals that latch, and `pins_oe` equals the direction register at 0x04.
- R4: When type1=0, type2=0 and type0=1 for a line, only a 0-to-1 transition of its synchronized sample sets its status bit.
- R5: When type1=0, type2=0 and type0=0 for a line, only a 1-to-0 transition sets its status bit.
- R6: When type1=0 and type2=1 for a line, either transition sets its status bit, whatever type0 holds.
- R7: When type1=1 for a line, its status bit is set on every cycle the synchronized level equals type0 (1 = high, 0 = low). If the level is still active, a status bit cleared by software reads set again.
- R8: A write to offset 0x18 clears each status bit written with 1 and leaves bits written with 0 unchanged. An event in the same cycle as a clear wins, so the bit stays set.
- R9: Status bits are set regardless of the enable register at 0x08. `irq` is high exactly when some line has both its status bit and its enable bit set.
- R10: type2 has no effect on a line whose type1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pins_in | input | NLINES (32) | Asynchronous input pins |
| pins_out | output | NLINES (32) | Output latch contents |
| pins_oe | output | NLINES (32) | Per-line output enable (direction) |
| irq | output | 1 | Aggregated interrupt |

## Verification
Eight lines in one bank get different trigger modes. The pins are then swung low and then high together. Each status pattern therefore separates rising, falling and dual-edge lines in a single read, including a dual-edge line whose type0 is 1. Two level-mode lines, one of which also has type2 set, are held active across clears. This shows the bit re-arming, the set-over-clear priority, and that type2 is ignored in level mode. A read of the value register one edge after a pin change, followed by a read the next edge, pins down the synchronizer latency. The enable register is moved between masking and unmasking pending lines to tell the status bit apart from the interrupt output.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int unsigned BUS_W = 32;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_VALUE  = 3'd0,
      SEL_DIR    = 3'd1,
      SEL_ENABLE = 3'd2,
      SEL_POL    = 3'd3,
      SEL_LEVEL  = 3'd4,
      SEL_DUAL   = 3'd5,
      SEL_STATUS = 3'd6,
      SEL_LATCH  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] level,
   input  logic [W-1:0] dual,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sample;
   end

   for (genvar b = 0; b < int'(W); b++) begin : g_line
      logic rise, fall, edge_hit, level_hit;
      always_comb begin
         rise      = sample[b] & ~prev_q[b];
         fall      = ~sample[b] & prev_q[b];
         edge_hit  = dual[b] ? (rise | fall) : (pol[b] ? rise : fall);
         level_hit = (sample[b] == pol[b]);
         evt[b]    = level[b] ? level_hit : edge_hit;
      end
   end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
   import gpio_evt_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned IW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  logic [IW-1:0]    word_idx,
   input  logic [BUS_W-1:0] wdata,
   input  logic [W-1:0]     sync_in,
   input  logic [W-1:0]     evt,
   output logic [BUS_W-1:0] rdata,
   output logic [W-1:0]     latch_q,
   output logic [W-1:0]     dir_q,
   output logic [W-1:0]     en_q,
   output logic [W-1:0]     pol_q,
   output logic [W-1:0]     level_q,
   output logic [W-1:0]     dual_q,
   output logic [W-1:0]     status_q
);
   localparam int unsigned HI_W = IW - SEL_W;

   logic     in_range;
   reg_sel_e sel;
   logic     wr_hit;
   logic [W-1:0] wbits, clr_mask;

   if (HI_W > 0) begin : g_hi_dec
      assign in_range = (word_idx[IW-1:SEL_W] == '0);
   end else begin : g_no_hi
      assign in_range = 1'b1;
   end

   assign sel      = reg_sel_e'(word_idx[SEL_W-1:0]);
   assign wr_hit   = wen & in_range;
   assign wbits    = wdata[W-1:0];
   assign clr_mask = (wr_hit && sel == SEL_STATUS) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q  <= '0;
         dir_q    <= '0;
         en_q     <= '0;
         pol_q    <= '0;
         level_q  <= '0;
         dual_q   <= '0;
         status_q <= '0;
      end else begin
         if (wr_hit) begin
            case (sel)
               SEL_VALUE:  latch_q <= wbits;
               SEL_DIR:    dir_q   <= wbits;
               SEL_ENABLE: en_q    <= wbits;
               SEL_POL:    pol_q   <= wbits;
               SEL_LEVEL:  level_q <= wbits;
               SEL_DUAL:   dual_q  <= wbits;
               default:    ;
            endcase
         end
         status_q <= (status_q & ~clr_mask) | evt;
      end
   end

   always_comb begin
      rdata = '0;
      if (in_range) begin
         case (sel)
            SEL_VALUE:  rdata[W-1:0] = sync_in;
            SEL_DIR:    rdata[W-1:0] = dir_q;
            SEL_ENABLE: rdata[W-1:0] = en_q;
            SEL_POL:    rdata[W-1:0] = pol_q;
            SEL_LEVEL:  rdata[W-1:0] = level_q;
            SEL_DUAL:   rdata[W-1:0] = dual_q;
            SEL_STATUS: rdata[W-1:0] = status_q;
            SEL_LATCH:  rdata[W-1:0] = latch_q;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int unsigned NLINES      = 32,
   parameter int unsigned AW          = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [AW-1:0]     reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   input  logic [NLINES-1:0] pins_in,
   output logic [NLINES-1:0] pins_out,
   output logic [NLINES-1:0] pins_oe,
   output logic              irq
);
   localparam int unsigned IW = AW - 2;

   if (NLINES < 1 || NLINES > BUS_W) begin : g_bad_lines
      $error("gpio_evt_bank: NLINES must be 1..32");
   end
   if (AW < 5) begin : g_bad_aw
      $error("gpio_evt_bank: AW must be at least 5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_evt_bank: SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0] sync_v, evt_v;
   logic [NLINES-1:0] latch_v, dir_v, en_v, pol_v, level_v, dual_v, status_v;

   gpio_evt_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins_in),
      .dout (sync_v)
   );

   gpio_evt_detect #(.W(NLINES)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .sample(sync_v),
      .pol   (pol_v),
      .level (level_v),
      .dual  (dual_v),
      .evt   (evt_v)
   );

   gpio_evt_regs #(.W(NLINES), .IW(IW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen     (reg_wen),
      .word_idx(reg_addr[AW-1:2]),
      .wdata   (reg_wdata),
      .sync_in (sync_v),
      .evt     (evt_v),
      .rdata   (reg_rdata),
      .latch_q (latch_v),
      .dir_q   (dir_v),
      .en_q    (en_v),
      .pol_q   (pol_v),
      .level_q (level_v),
      .dual_q  (dual_v),
      .status_q(status_v)
   );

   assign pins_out = latch_v;
   assign pins_oe  = dir_v;
   assign irq      = |(status_v & en_v);
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk #(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wen,
   input logic [AW-1:0] reg_addr,
   input logic [31:0]   reg_wdata,
   input logic [W-1:0]  pins_in,
   input logic [W-1:0]  pins_out,
   input logic          irq,
   input logic [W-1:0]  sync_v,
   input logic [W-1:0]  status_v,
   input logic [W-1:0]  en_v,
   input logic [W-1:0]  evt_v
);
   logic [1:0]   age_q;
   logic         stat_wr;
   logic [W-1:0] clr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               age_q <= '0;
      else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
   end

   assign stat_wr  = reg_wen && (reg_addr == AW'(8'h18));
   assign clr_bits = stat_wr ? reg_wdata[W-1:0] : '0;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (pins_out == '0 && !irq));

   // R2
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (sync_v == $past(pins_in, 2)));

   // R3
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == '0) |=> (pins_out == $past(reg_wdata[W-1:0])));

   // R8
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((status_v & $past(reg_wdata[W-1:0]) & ~$past(evt_v)) == '0));

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(status_v) & ~$past(clr_bits)) & ~status_v) == '0));

   // R9
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_v & $past(evt_v)) == $past(evt_v)));

   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v == '0) |-> !irq);
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.W(NLINES), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wen  (reg_wen),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .pins_in  (pins_in),
   .pins_out (pins_out),
   .irq      (irq),
   .sync_v   (sync_v),
   .status_v (status_v),
   .en_v     (en_v),
   .evt_v    (evt_v)
);

// File: tb/gpio_evt_bank_test.sv
`timescale 1ns/1ps
module gpio_evt_bank_test;
   localparam int N = 32;
   localparam logic [4:0] A_VAL = 5'h00, A_DIR = 5'h04, A_EN = 5'h08, A_POL = 5'h0C,
                          A_LVL = 5'h10, A_DUAL = 5'h14, A_STAT = 5'h18, A_LAT = 5'h1C;
   localparam int SRC_RD = 0, SRC_IRQ = 1, SRC_OUT = 2, SRC_OE = 3;

   typedef struct {
      int          src;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wen = 1'b0;
   logic [4:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  pins_in = '0;
   logic [N-1:0]  pins_out, pins_oe;
   logic          irq;

   item_t sb_q[$];
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_evt_bank uut (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pins_in(pins_in),
      .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
   );

   // monitor: compares queued expectations on the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = sb_q.pop_front();
         case (it.src)
            SRC_RD:  got = reg_rdata;
            SRC_IRQ: got = {31'd0, irq};
            SRC_OUT: got = pins_out;
            default: got = pins_oe;
         endcase
         n_vec++;
         if (got !== it.exp) begin
            n_bad++;
            $display("FAIL %s: src %0d got %h expected %h", it.req, it.src, got, it.exp);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(posedge clk); #1;
      reg_wen = 1'b0;
   endtask

   task automatic expect_at(input int src, input logic [4:0] a, input logic [31:0] e, input string req);
      item_t it;
      reg_addr = a;
      it.src = src; it.exp = e; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      @(posedge clk); #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      for (int a = 0; a < 8; a++) expect_at(SRC_RD, 5'(a*4), 32'h0, "R1");
      expect_at(SRC_IRQ, A_VAL, 32'h0, "R1");
      expect_at(SRC_OUT, A_VAL, 32'h0, "R1");
      expect_at(SRC_OE,  A_VAL, 32'h0, "R1");

      // R3 latch and direction, R2 value is pins not latch
      wr(A_VAL, 32'hA5A5_0F0F);
      expect_at(SRC_RD,  A_LAT, 32'hA5A5_0F0F, "R3");
      expect_at(SRC_OUT, A_VAL, 32'hA5A5_0F0F, "R3");
      expect_at(SRC_RD,  A_VAL, 32'h0, "R2");
      wr(A_DIR, 32'hFFFF_0000);
      expect_at(SRC_OE, A_VAL, 32'hFFFF_0000, "R3");

      // R2 synchronizer latency
      pins_in = 32'h0000_00FF;
      step(1);
      expect_at(SRC_RD, A_VAL, 32'h0, "R2");
      expect_at(SRC_RD, A_VAL, 32'h0000_00FF, "R2");
      step(2);
      // R5 default falling mode ignores rising edges
      expect_at(SRC_RD, A_STAT, 32'h0, "R5");

      // bits0-3 rising, bit4 dual with pol 1, bit5 dual with pol 0, bits6-7 falling
      wr(A_POL, 32'h0000_001F);
      wr(A_DUAL, 32'h0000_0030);
      wr(A_STAT, 32'hFFFF_FFFF);
      pins_in = 32'h0000_0000;
      step(3);
      expect_at(SRC_RD, A_STAT, 32'h0000_00F0, "R5 R6");
      wr(A_STAT, 32'h0000_00FF);
      expect_at(SRC_RD, A_STAT, 32'h0, "R8");
      pins_in = 32'h0000_00FF;
      step(3);
      expect_at(SRC_RD, A_STAT, 32'h0000_003F, "R4 R6");

      // R8 partial clear, zero write leaves bits
      wr(A_STAT, 32'h0000_000F);
      expect_at(SRC_RD, A_STAT, 32'h0000_0030, "R8");
      wr(A_STAT, 32'h0000_0000);
      expect_at(SRC_RD, A_STAT, 32'h0000_0030, "R8");

      // R9 masking
      expect_at(SRC_IRQ, A_VAL, 32'h0, "R9");
      wr(A_EN, 32'h0000_0010);
      expect_at(SRC_IRQ, A_VAL, 32'h1, "R9");
      wr(A_STAT, 32'h0000_0010);
      expect_at(SRC_RD,  A_STAT, 32'h0000_0020, "R8");
      expect_at(SRC_IRQ, A_VAL, 32'h0, "R9");

      // R7 R10: bit8 level high (dual also set), bit9 level low
      wr(A_POL, 32'h0000_011F);
      wr(A_DUAL, 32'h0000_0130);
      wr(A_LVL, 32'h0000_0300);
      step(1);
      expect_at(SRC_RD, A_STAT, 32'h0000_0220, "R7 R10");
      expect_at(SRC_IRQ, A_VAL, 32'h0, "R9");
      wr(A_STAT, 32'h0000_0200);
      expect_at(SRC_RD, A_STAT, 32'h0000_0220, "R8");
      wr(A_EN, 32'h0000_0200);
      expect_at(SRC_IRQ, A_VAL, 32'h1, "R9");
      pins_in = 32'h0000_01FF;
      step(3);
      expect_at(SRC_RD, A_STAT, 32'h0000_0320, "R7");
      wr(A_STAT, 32'hFFFF_FFFF);
      expect_at(SRC_RD, A_STAT, 32'h0000_0300, "R7");
      pins_in = 32'h0000_02FF;
      step(3);
      wr(A_STAT, 32'hFFFF_FFFF);
      expect_at(SRC_RD,  A_STAT, 32'h0, "R7 R10");
      expect_at(SRC_IRQ, A_VAL, 32'h0, "R9");
      expect_at(SRC_RD,  A_VAL, 32'h0000_02FF, "R2");
      expect_at(SRC_RD,  A_LAT, 32'hA5A5_0F0F, "R3");

      step(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule